// File: doc/BRIEF.md
# Circular-Pipeline Longest-Prefix-Match Engine

This block resolves 32-bit IPv4 destination addresses to a route result by walking a three-level sparse tree held in one synchronous RAM. The root level is indexed directly by the upper sixteen address bits, and each deeper level consumes one further byte. A lookup costs one, two or three dependent reads and ends at the first leaf it meets.

All lookups share one RAM port through a feedback loop. An accepted address draws a token from a reorder buffer, issues its root read, and parks its token, its unconsumed low sixteen bits and its level in a context queue. Every RAM response is matched with the head of that queue. A pointer word sends the lookup round again, and a leaf word retires the lookup into its token slot. A short lookup can finish before a longer one that entered earlier. The reorder buffer still hands results out in the order the addresses were accepted. A new address can be accepted in the same cycle that a leaf retires, so the exit path does not cost any throughput.

The RAM side is request/response with valid and ready handshakes. Responses return in request order after any number of cycles, and the engine dequeues each one explicitly, so no fixed latency is assumed.

Top module: `lpm_circ_engine`

## Requirements
- R1: After reset, out_valid, mem_req_valid and mem_rsp_deq are 0. With mem_req_ready high and no response pending, in_ready is 1.
- R2: When an address is accepted (in_valid and in_ready high), mem_req_valid is high in that same cycle and mem_req_addr equals in_addr[31:16], zero-extended.
- R3: A RAM word has its leaf flag at bit ADDR_W (1 means leaf). Bits ADDR_W-1:0 hold the payload: the result for a leaf, the base pointer otherwise. A lookup's result equals the payload of the leaf that ends it.
- R4: For a pointer word, the next request goes to payload + in_addr[15:8] after the root read, and to payload + in_addr[7:0] after the second read. It is issued in the cycle the pointer response is dequeued.
- R5: A lookup issues no further RAM request once a leaf is returned, so it uses between one and three reads. A word read at the third level is always a leaf.
- R6: Results leave on out_data in the order their addresses were accepted, even when a later lookup finishes first.
- R7: A leaf response being retired does not block entry: a new address can be accepted in the same cycle.
- R8: Recirculation takes priority on the RAM request port. No address is accepted while a pointer response is waiting.
- R9: With CB_DEPTH lookups accepted but not yet read out, in_ready stays 0 until a result is taken.
- R10: Results are correct for any RAM latency and any mem_req_ready pattern. mem_rsp_deq is only asserted while mem_rsp_valid is high.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An address is offered |
| in_addr | input | 32 | Address to resolve |
| in_ready | output | 1 | Address accepted this cycle when in_valid is high |
| mem_req_valid | output | 1 | RAM read request |
| mem_req_ready | input | 1 | RAM takes the request this cycle |
| mem_req_addr | output | ADDR_W | RAM read address |
| mem_rsp_valid | input | 1 | Oldest RAM response is available |
| mem_rsp_data | input | ADDR_W+1 | Oldest RAM response word (leaf flag plus payload) |
| mem_rsp_deq | output | 1 | Consume the oldest RAM response |
| out_valid | output | 1 | Oldest result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ADDR_W | Route result |

## Verification
A fixed address set mixes one-, two- and three-read lookups so that short walks overtake long ones. Comparing each result against an independent tree walk shows both the pointer arithmetic and the reordering. Single lookups with the issued RAM addresses logged separate a correct per-level index from a mis-shifted byte, and show that the walk stops at a leaf. Holding the consumer off shows the token limit and the output hold. Rerunning the set with one-cycle and seven-cycle RAM latency under a toggling mem_req_ready and out_ready shows that nothing relies on fixed timing. Port monitors count same-cycle entry with exit and look for any entry made while a pointer response was waiting.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LVL_W  = 2;
  localparam int ROOT_W = 16;
  localparam int STRIDE = 8;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_ROOT = 2'd0;
  localparam lvl_t LVL_LAST = 2'd2;
endpackage

// File: rtl/lpm_ctx_fifo.sv
module lpm_ctx_fifo #(
  parameter int WIDTH = 21,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_d = push ? step(wr_q) : wr_q;
    rd_d = pop  ? step(rd_q) : rd_q;
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= din;
  end

  assign dout  = slot_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  assert_fifo_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full);
  assert_fifo_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lpm_cbuf.sv
module lpm_cbuf #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 8,
  parameter int TOK_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_take,
  output logic              tok_avail,
  output logic [TOK_W-1:0]  tok_id,
  input  logic              put_en,
  input  logic [TOK_W-1:0]  put_id,
  input  logic [DATA_W-1:0] put_data,
  input  logic              res_take,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  done_q, done_d;
  logic [TOK_W-1:0]  alloc_q, alloc_d, ret_q, ret_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  function automatic logic [TOK_W-1:0] step(input logic [TOK_W-1:0] p);
    return (p == TOK_W'(DEPTH - 1)) ? '0 : p + TOK_W'(1);
  endfunction

  always_comb begin
    alloc_d = tok_take ? step(alloc_q) : alloc_q;
    ret_d   = res_take ? step(ret_q)   : ret_q;
    unique case ({tok_take, res_take})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
    done_d = done_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (put_en && put_id == TOK_W'(i))  done_d[i] = 1'b1;
      if (res_take && ret_q == TOK_W'(i)) done_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= '0;
      ret_q   <= '0;
      cnt_q   <= '0;
      done_q  <= '0;
    end else begin
      alloc_q <= alloc_d;
      ret_q   <= ret_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = put_en && (put_id == TOK_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) data_q[g] <= put_data;
    end
  end

  assign tok_avail = (cnt_q != CW'(DEPTH));
  assign tok_id    = alloc_q;
  assign res_valid = done_q[ret_q];
  assign res_data  = data_q[ret_q];

  assert_put_open_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    put_en |-> !done_q[put_id]);
  assert_token_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tok_take |-> tok_avail);
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_take) |=> (res_valid && $stable(res_data)));
endmodule

// File: rtl/lpm_circ_engine.sv
module lpm_circ_engine
  import lpm_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int FIFO_DEPTH = 8,
  parameter int CB_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              in_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W:0]   mem_rsp_data,
  output logic              mem_rsp_deq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_data
);
  localparam int TOK_W = $clog2(CB_DEPTH);
  localparam int CTX_W = TOK_W + ROOT_W + LVL_W;

  logic              tok_avail;
  logic [TOK_W-1:0]  tok_id;
  logic [CTX_W-1:0]  ctx_in, ctx_head;
  logic [TOK_W-1:0]  h_tok;
  logic [ROOT_W-1:0] h_rem;
  lvl_t              h_lvl;
  logic              fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic              rsp_leaf;
  logic [ADDR_W-1:0] rsp_payload;
  logic              exit_fire, recirc_fire, enter_fire, ptr_waiting;

  assign {h_tok, h_rem, h_lvl} = ctx_head;
  // R3: leaf flag on top, payload below it
  assign rsp_leaf    = mem_rsp_data[ADDR_W];
  assign rsp_payload = mem_rsp_data[ADDR_W-1:0];

  always_comb begin
    ptr_waiting = mem_rsp_valid && !rsp_leaf;
    exit_fire   = mem_rsp_valid && rsp_leaf;
    recirc_fire = ptr_waiting && mem_req_ready;
    // R7: a retiring leaf frees a queue slot in the same cycle
    in_ready    = tok_avail && (!fifo_full || exit_fire) && mem_req_ready && !ptr_waiting;
    enter_fire  = in_valid && in_ready;
    fifo_push   = enter_fire || recirc_fire;
    fifo_pop    = exit_fire || recirc_fire;
    mem_req_valid = enter_fire || recirc_fire;
    if (recirc_fire) begin
      // R4: base pointer plus the next unconsumed byte
      mem_req_addr = rsp_payload + ADDR_W'(h_rem[ROOT_W-1 -: STRIDE]);
      ctx_in = {h_tok, h_rem[ROOT_W-STRIDE-1:0], {STRIDE{1'b0}}, lvl_t'(h_lvl + 1'b1)};
    end else begin
      // R2: root read indexed by the upper half
      mem_req_addr = ADDR_W'(in_addr[31:ROOT_W]);
      ctx_in = {tok_id, in_addr[ROOT_W-1:0], LVL_ROOT};
    end
  end

  assign mem_rsp_deq = fifo_pop;

  lpm_ctx_fifo #(.WIDTH(CTX_W), .DEPTH(FIFO_DEPTH)) ctx_q_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (ctx_in),
    .dout  (ctx_head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  lpm_cbuf #(.DATA_W(ADDR_W), .DEPTH(CB_DEPTH), .TOK_W(TOK_W)) reorder_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_take  (enter_fire),
    .tok_avail (tok_avail),
    .tok_id    (tok_id),
    .put_en    (exit_fire),
    .put_id    (h_tok),
    .put_data  (rsp_payload),
    .res_take  (out_valid && out_ready),
    .res_valid (out_valid),
    .res_data  (out_data)
  );

  assert_last_level_leaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !fifo_empty && h_lvl == LVL_LAST) |-> rsp_leaf);
  assert_rsp_has_context_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !fifo_empty);
  assert_deq_when_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_deq |-> mem_rsp_valid);
  assert_req_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |-> in_valid);
endmodule

// File: tb/lpm_circ_engine_tb_top.sv
module lpm_circ_engine_tb_top;
  localparam int AW = 18;
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    32'h0A12C805, 32'h05010203, 32'h0A120101, 32'h07140703,
    32'h07140900, 32'hFFFFFFFF, 32'h00000000, 32'h0A12C8FF,
    32'h0714FF00, 32'h12345678, 32'h0A12C800, 32'h07140700};

  logic clk, rst_n;
  logic in_valid, in_ready, mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_deq;
  logic out_valid, out_ready;
  logic [31:0] in_addr;
  logic [AW-1:0] mem_req_addr, out_data;
  logic [AW:0] mem_rsp_data;

  int n_chk, n_fail, n_acc, n_out;
  int ram_lat, rr_mode, or_mode;
  int overlap, prio_viol, hold_viol, deq_viol, n_log;
  bit tog, done;
  logic [AW-1:0] exp_q [256];
  logic [AW-1:0] req_log [64];
  logic prev_stall;
  logic [AW-1:0] prev_data;

  lpm_circ_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_deq(mem_rsp_deq),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [AW:0] tree_word(input logic [AW-1:0] a);
    if (a[17:16] == 2'b00) begin
      if (a[15:0] == 16'h0A12) return {1'b0, 18'h10000};
      if (a[15:0] == 16'h0714) return {1'b0, 18'h10100};
      return {1'b1, 2'b00, a[15:0] ^ 16'h5A5A};
    end
    case (a[17:8])
      10'h100: return (a[7:0] == 8'd200) ? {1'b0, 18'h10200} : {1'b1, 18'h20000 + 18'(a[7:0])};
      10'h101: return (a[7:0] == 8'd7)   ? {1'b0, 18'h10300} : {1'b1, 18'h21000 + 18'(a[7:0])};
      10'h102: return {1'b1, 18'h24000 + 18'(a[7:0])};
      10'h103: return {1'b1, 18'h34000 + 18'(a[7:0])};
      default: return {1'b1, 18'h3FFFF};
    endcase
  endfunction

  function automatic logic [AW-1:0] lpm_ref(input logic [31:0] ip);
    logic [AW:0] w;
    w = tree_word(AW'(ip[31:16]));
    if (w[AW]) return w[AW-1:0];
    w = tree_word(w[AW-1:0] + AW'(ip[15:8]));
    if (w[AW]) return w[AW-1:0];
    w = tree_word(w[AW-1:0] + AW'(ip[7:0]));
    return w[AW-1:0];
  endfunction

  // RAM model: in-order responses after ram_lat cycles
  logic [AW-1:0] ram_addr [16];
  int ram_due [16];
  logic [4:0] ram_wp, ram_rp;
  int ram_cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_wp <= '0; ram_rp <= '0; ram_cyc <= 0;
    end else begin
      ram_cyc <= ram_cyc + 1;
      if (mem_req_valid && mem_req_ready) begin
        ram_addr[ram_wp[3:0]] <= mem_req_addr;
        ram_due[ram_wp[3:0]]  <= ram_cyc + ram_lat;
        ram_wp <= ram_wp + 5'd1;
      end
      if (mem_rsp_deq && ram_wp != ram_rp) ram_rp <= ram_rp + 5'd1;
    end
  end
  assign mem_rsp_valid = (ram_wp != ram_rp) && (ram_due[ram_rp[3:0]] <= ram_cyc);
  assign mem_rsp_data  = tree_word(ram_addr[ram_rp[3:0]]);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // handshake drivers
  initial begin
    forever begin
      @(negedge clk);
      tog = ~tog;
      mem_req_ready = (rr_mode == 0) ? 1'b1 : tog;
      out_ready = (or_mode == 0) ? 1'b1 : (or_mode == 1) ? 1'b0 : ~tog;
    end
  end

  // port monitors and result collector
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (in_valid && in_ready && mem_rsp_valid && mem_rsp_data[AW]) overlap++;
      if (in_valid && in_ready && mem_rsp_valid && !mem_rsp_data[AW]) prio_viol++;
      if (mem_rsp_deq && !mem_rsp_valid) deq_viol++;
      if (prev_stall && (!out_valid || out_data !== prev_data)) hold_viol++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (mem_req_valid && mem_req_ready && n_log < 64) begin
        req_log[n_log] = mem_req_addr;
        n_log++;
      end
      if (out_valid && out_ready) begin
        chk(out_data === exp_q[n_out], "R6 R3 in-order result", out_data, exp_q[n_out]);
        n_out++;
      end
    end
  end

  task automatic send(input logic [31:0] a);
    bit acc;
    in_valid = 1'b1;
    in_addr = a;
    acc = 1'b0;
    while (!acc) begin
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) begin
        exp_q[n_acc] = lpm_ref(a);
        n_acc++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (n_out < n_acc && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk(n_out == n_acc, tag, n_out, n_acc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
    ram_lat = 3; rr_mode = 0; or_mode = 0;
    prev_stall = 1'b0; prev_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && mem_req_valid == 1'b0 && mem_rsp_deq == 1'b0, "R1 outputs idle",
        {out_valid, mem_req_valid, mem_rsp_deq}, 0);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    @(negedge clk);

    // table walk, back to back
    for (int i = 0; i < NV; i++) send(VEC[i]);
    drain("R6 table drained");
    chk(overlap > 0, "R7 entry with exit same cycle", overlap, 1);
    chk(prio_viol == 0, "R8 entry during pointer response", prio_viol, 0);

    // issued addresses of a three-read lookup
    n_log = 0;
    send(32'h0A12C805);
    drain("R4 single drained");
    chk(n_log == 3, "R5 three reads", n_log, 3);
    chk(req_log[0] == 18'h00A12, "R2 root index", req_log[0], 18'h00A12);
    chk(req_log[1] == 18'h100C8, "R4 second index", req_log[1], 18'h100C8);
    chk(req_log[2] == 18'h10205, "R4 third index", req_log[2], 18'h10205);
    n_log = 0;
    send(32'h12345678);
    drain("R5 single drained");
    chk(n_log == 1, "R5 stop at root leaf", n_log, 1);

    // token exhaustion with consumer held off
    or_mode = 1;
    for (int i = 0; i < 8; i++) send(VEC[i]);
    begin
      int leak;
      leak = 0;
      in_valid = 1'b1; in_addr = VEC[8];
      repeat (20) begin
        #1 if (in_ready) leak++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      chk(leak == 0, "R9 stall with no token", leak, 0);
      chk(out_valid == 1'b1, "R11 result waiting", out_valid, 1);
    end
    or_mode = 0;
    send(VEC[8]);
    drain("R9 drained after stall");
    chk(hold_viol == 0, "R11 output held", hold_viol, 0);

    // other latencies with throttled handshakes
    ram_lat = 1; rr_mode = 1; or_mode = 2;
    for (int i = 0; i < NV; i++) send(VEC[i]);
    drain("R10 latency 1 drained");
    ram_lat = 7;
    for (int i = 0; i < NV; i++) send(VEC[NV-1-i]);
    drain("R10 latency 7 drained");
    chk(deq_viol == 0, "R10 dequeue only valid", deq_viol, 0);
    chk(prio_viol == 0, "R8 priority throttled", prio_viol, 0);
    chk(hold_viol == 0, "R11 hold throttled", hold_viol, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule